// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. The stream has three lines: a bit clock, a word clock whose level marks the channel, and a single data line that carries two's-complement samples, most significant bit first. All three lines arrive asynchronously to the system clock. Each one passes through a two-flop synchronizer, and every decision is taken on the synchronized copies. Data is taken on each rising edge of the bit clock. The bit clock may come from an external pin or an internal generator; another block makes that choice.

Three framings are accepted. In I2S framing the left word is sent while the word clock is low, and its first bit comes one bit clock after the word-clock change. In left-justified framing the left word is sent while the word clock is high, and its first bit comes on the first bit clock of the half-frame. In right-justified framing the word is placed against the end of the half-frame: its LSB is the last bit before the next word-clock change, and its length is chosen from 16, 18, 20 or 24 bits. Every output word is 24 bits wide and left-aligned. Shorter words are zero-filled at the LSB end.

After the right word of a frame is complete, the left and right outputs are loaded together and a one-cycle strobe is raised. The framing and word-length selects are static and may be changed only while the block is held in reset.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_sel` = 0 (I2S), the word sent while `wclk_in` is low is the left sample. A word's MSB is the bit sampled on the second bit-clock rise after the word-clock change, and the following bits carry the lower bits in order.
- R2: With `fmt_sel` = 1 (left-justified), the word sent while `wclk_in` is high is the left sample. The MSB is the bit sampled on the first bit-clock rise that sees the new word-clock level.
- R3: With `fmt_sel` = 2 (right-justified), the LSB is the last bit sampled before the word-clock change. `rj_len_sel` codes 0, 1, 2 and 3 select word lengths of 16, 18, 20 and 24 bits. The word is output left-aligned in 24 bits with the unused low bits zero. The left sample is sent while `wclk_in` is high.
- R4: In I2S and left-justified framing, a half-frame of fewer than 24 bits yields its bits as the top bits of the output, with the remaining low bits zero.
- R5: In I2S and left-justified framing, bits after the 24th bit of a half-frame do not change the output word.
- R6: Frames of 32, 48 and 64 bit clocks per word-clock period are all received correctly. Right-justified framing needs at least twice the word length per frame.
- R7: `frame_valid` is high for exactly one system clock per complete stereo frame, in the cycle in which `left_out` and `right_out` take their new values. The outputs hold their values at all other times.
- R8: After reset, `left_out` and `right_out` are zero and `frame_valid` is low. No strobe is produced for a frame whose left word began before the first word-clock change seen after reset.
- R9: In right-justified framing, bits that come before the word inside a half-frame do not change the output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified |
| rj_len_sel | input | 2 | Right-justified word length: 0=16, 1=18, 2=20, 3=24 bits |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| wclk_in | input | 1 | Word clock, level selects the channel, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| left_out | output | 24 | Left sample, left-aligned two's complement |
| right_out | output | 24 | Right sample, left-aligned two's complement |
| frame_valid | output | 1 | One-cycle strobe when both samples update |

## Verification
The hardest case to reach from the ports is the start of a stream. Nothing at the ports shows where a frame begins, so a half-frame that was already under way at reset must be dropped and must not be paired with anything. To reach this, every configuration starts with a fresh reset followed by a full throwaway frame. Because its words start before the first word-clock change, no strobe may come from it, and the bench checks that the number of strobes equals the number of real frames sent. The unused bit positions are filled with ones, and the frame lengths are swept from 32 to 64. This drives both the zero-fill of short words and the discarding of extra bits.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2
  } fmt_e;

  // Right-justified word length for a select code
  function automatic logic [5:0] rj_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd18;
      2'd2:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

  // Move the newest n bits of the history to the top of the word
  function automatic logic [SAMPLE_W-1:0] rj_align(input logic [SAMPLE_W-1:0] hist,
                                                   input logic [5:0] n);
    return hist << (SAMPLE_W - int'(n));
  endfunction

  // Mask of the bit positions not yet written after cnt bits
  function automatic logic [SAMPLE_W-1:0] unfilled_mask(input logic [CNT_W-1:0] cnt);
    logic [SAMPLE_W-1:0] m;
    for (int i = 0; i < SAMPLE_W; i++) m[i] = (i < (SAMPLE_W - int'(cnt)));
    return m;
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= async_in;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sar_slot_tracker.sv
module sar_slot_tracker
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  fmt_e fmt,
  input  logic s_bclk,
  input  logic s_wclk,
  input  logic s_sdata,
  output logic bit_stb,
  output logic bit_val,
  output logic slot_start,
  output logic slot_end,
  output logic end_right,
  output logic new_right
);
  logic bclk_q, w_prev, seen, i2s_pend, cur_right, slot_ok;
  logic wclk_flip;

  assign bit_stb   = s_bclk & ~bclk_q;
  assign bit_val   = s_sdata;
  assign wclk_flip = bit_stb & seen & (s_wclk != w_prev);

  always_comb begin
    if (fmt == FMT_I2S) begin
      // word begins one bit after the word-clock change; left while low
      slot_start = bit_stb & i2s_pend;
      new_right  = w_prev;
    end else begin
      // word slot equals the word-clock half; left while high
      slot_start = wclk_flip;
      new_right  = ~s_wclk;
    end
  end

  assign slot_end  = slot_start & slot_ok;
  assign end_right = cur_right;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      w_prev    <= 1'b0;
      seen      <= 1'b0;
      i2s_pend  <= 1'b0;
      cur_right <= 1'b0;
      slot_ok   <= 1'b0;
    end else begin
      bclk_q <= s_bclk;
      if (bit_stb) begin
        w_prev   <= s_wclk;
        seen     <= 1'b1;
        i2s_pend <= wclk_flip;
      end
      if (slot_start) begin
        cur_right <= new_right;
        slot_ok   <= 1'b1;
      end
    end
  end

  // R1 R2: finished slots alternate between channels
  a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> (end_right != new_right));
endmodule

// File: rtl/sar_word_capture.sv
module sar_word_capture
  import sar_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  fmt_e                fmt,
  input  logic [1:0]          rj_len_sel,
  input  logic                bit_stb,
  input  logic                bit_val,
  input  logic                slot_start,
  input  logic                slot_end,
  output logic [SAMPLE_W-1:0] word
);
  logic [SAMPLE_W-1:0] lead_word;
  logic [SAMPLE_W-1:0] tail_hist;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] first_bit;

  assign first_bit = {bit_val, {(SAMPLE_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_word <= '0;
      tail_hist <= '0;
      cnt       <= '0;
    end else if (bit_stb) begin
      tail_hist <= slot_start ? {{(SAMPLE_W-1){1'b0}}, bit_val}
                              : {tail_hist[SAMPLE_W-2:0], bit_val};
      if (slot_start) begin
        lead_word <= first_bit;
        cnt       <= CNT_W'(1);
      end else if (cnt < CNT_W'(SAMPLE_W)) begin
        lead_word <= lead_word | (first_bit >> cnt);
        cnt       <= cnt + CNT_W'(1);
      end
    end
  end

  assign word = (fmt == FMT_RJ) ? rj_align(tail_hist, rj_bits(rj_len_sel)) : lead_word;

  // R4: unwritten low positions are zero when a leading word closes
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && fmt != FMT_RJ) |-> ((lead_word & unfilled_mask(cnt)) == '0));
  // R5: the fill count never passes the word width
  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SAMPLE_W));
endmodule

// File: rtl/sar_frame_pair.sv
module sar_frame_pair
  import sar_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_end,
  input  logic                end_right,
  input  logic [SAMPLE_W-1:0] word,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                frame_valid
);
  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold   <= '0;
      have_left   <= 1'b0;
      left_out    <= '0;
      right_out   <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (slot_end) begin
        if (!end_right) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_out    <= left_hold;
          right_out   <= word;
          frame_valid <= 1'b1;
          have_left   <= 1'b0;
        end
      end
    end
  end

  // R7: single-cycle strobe
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  // R7: outputs change only together with the strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(left_out) && $stable(right_out)));
  // R8: a right word without a left partner yields no strobe
  a_r8_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && end_right && !have_left) |=> !frame_valid);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          rj_len_sel,
  input  logic                bclk_in,
  input  logic                wclk_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                frame_valid
);
  logic [2:0] synced;
  fmt_e       fmt;
  logic       bit_stb, bit_val, slot_start, slot_end, end_right, new_right;
  logic [SAMPLE_W-1:0] word;

  assign fmt = fmt_e'(fmt_sel);

  sar_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({bclk_in, wclk_in, sdata_in}),
    .sync_out(synced)
  );

  sar_slot_tracker u_track (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .s_bclk(synced[2]), .s_wclk(synced[1]), .s_sdata(synced[0]),
    .bit_stb(bit_stb), .bit_val(bit_val), .slot_start(slot_start),
    .slot_end(slot_end), .end_right(end_right), .new_right(new_right)
  );

  sar_word_capture u_cap (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .rj_len_sel(rj_len_sel),
    .bit_stb(bit_stb), .bit_val(bit_val), .slot_start(slot_start),
    .slot_end(slot_end), .word(word)
  );

  sar_frame_pair u_pair (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .end_right(end_right),
    .word(word), .left_out(left_out), .right_out(right_out),
    .frame_valid(frame_valid)
  );
endmodule

// File: tb/tb_serial_audio_rx.sv
`timescale 1ns/1ps
module tb_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [1:0]  rj_len_sel = 2'd0;
  logic        bclk_in = 1'b0, wclk_in = 1'b0, sdata_in = 1'b0;
  logic [23:0] left_out, right_out;
  logic        frame_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [23:0] exp_l [0:15];
  logic [23:0] exp_r [0:15];
  int exp_wr = 0, exp_rd = 0;
  string cur_tag = "R1";
  int half_len = 16, rj_n = 16;

  always #4 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .rj_len_sel(rj_len_sel),
    .bclk_in(bclk_in), .wclk_in(wclk_in), .sdata_in(sdata_in),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // strobe monitor: compare against the queue of expected frames
  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      if (exp_rd < exp_wr) begin
        check(cur_tag, left_out, exp_l[exp_rd]);
        check(cur_tag, right_out, exp_r[exp_rd]);
        exp_rd++;
      end else begin
        check("R8 unexpected strobe", 24'h1, 24'h0);
      end
    end
  end

  task automatic bit_out(input logic w, input logic d);
    @(negedge clk);
    wclk_in = w; sdata_in = d;
    repeat (4) @(negedge clk);
    bclk_in = 1'b1;
    repeat (4) @(negedge clk);
    bclk_in = 1'b0;
  endtask

  function automatic logic slot_bit(input logic [23:0] s, input int k);
    int pad;
    if (fmt_sel == 2'd2) begin
      pad = half_len - rj_n;
      return (k < pad) ? 1'b1 : s[23 - (k - pad)];
    end
    return (k < 24) ? s[23 - k] : 1'b1;
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] s);
    int keep;
    keep = (fmt_sel == 2'd2) ? rj_n : ((half_len < 24) ? half_len : 24);
    return s & (24'hFFFFFF << (24 - keep));
  endfunction

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
    for (int ch = 0; ch < 2; ch++) begin
      logic lvl, lvl_left;
      lvl_left = (fmt_sel == 2'd0) ? 1'b0 : 1'b1;
      lvl = (ch == 0) ? lvl_left : ~lvl_left;
      for (int k = 0; k < half_len; k++)
        bit_out((fmt_sel == 2'd0 && k == half_len - 1) ? ~lvl : lvl,
                slot_bit((ch == 0) ? l : r, k));
    end
  endtask

  task automatic run_cfg(input int fmt, input int len, input int ratio, input int cfg);
    logic [23:0] l, r;
    rst_n = 1'b0;
    fmt_sel = 2'(fmt); rj_len_sel = 2'(len);
    half_len = ratio / 2;
    rj_n = (len == 0) ? 16 : (len == 1) ? 18 : (len == 2) ? 20 : 24;
    exp_wr = 0; exp_rd = 0;
    case (fmt)
      0: cur_tag = (ratio == 32) ? "R1 R4 R6" : (ratio == 64) ? "R1 R5 R6" : "R1 R6";
      1: cur_tag = (ratio == 32) ? "R2 R4 R6" : (ratio == 64) ? "R2 R5 R6" : "R2 R6";
      default: cur_tag = (half_len > rj_n) ? "R3 R9 R6" : "R3 R6";
    endcase
    bclk_in = 1'b0; wclk_in = 1'b0; sdata_in = 1'b0;
    repeat (4) @(negedge clk);
    if (cfg == 0) begin
      check("R8 reset left", left_out, 24'h0);
      check("R8 reset right", right_out, 24'h0);
      check("R8 reset strobe", 24'(frame_valid), 24'h0);
    end
    rst_n = 1'b1;
    send_frame(24'h123456, 24'h654321);  // throwaway, must not be reported
    for (int f = 0; f < 5; f++) begin
      case (f)
        0: begin l = 24'h800000; r = 24'h7FFFFF; end
        1: begin l = 24'hFFFFFF; r = 24'h000001; end
        default: begin
          l = 24'((f * 32'h1A3F51 + cfg * 32'h0B7C3) ^ 32'h5A5A5A);
          r = 24'((f * 32'h2C9E17 + cfg * 32'h31D5) ^ 32'hA5C3E1);
        end
      endcase
      exp_l[exp_wr] = expect_word(l);
      exp_r[exp_wr] = expect_word(r);
      exp_wr++;
      send_frame(l, r);
    end
    send_frame(24'h0F0F0F, 24'hF0F0F0);  // flush, closes the last frame
    repeat (16) @(negedge clk);
    check("R7 R8 strobe count", 24'(exp_rd), 24'(exp_wr));
  endtask

  initial begin
    int cfg;
    cfg = 0;
    for (int fmt = 0; fmt < 3; fmt++)
      for (int len = 0; len < ((fmt == 2) ? 4 : 1); len++)
        for (int ri = 0; ri < 3; ri++) begin
          int ratio;
          ratio = 32 + ri * 16;
          if (fmt == 2 && ratio / 2 < ((len == 0) ? 16 : (len == 1) ? 18 : (len == 2) ? 20 : 24))
            continue;
          run_cfg(fmt, len, ratio, cfg);
          cfg++;
        end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule